// File: doc/BRIEF.md
# Heartbeat Time-Frame Marker Generator and Front-End Resynchroniser

The block keeps a free-running bunch-crossing counter and an orbit counter. Every time a configured number of orbits has gone by, it emits a one-cycle heartbeat. The heartbeat marks a time-frame boundary in a continuously read-out data stream. The trigger link is narrow, so the heartbeat carries only the low byte of the orbit number and no bunch-crossing value. The bunch-crossing position is implied: a heartbeat always coincides with crossing zero.

The same top also holds the matching front-end receiver. It takes the heartbeat after it has crossed the link, which enters through its own input pins so that the link can be modelled or disturbed outside the block. The receiver runs its own copy of the counters. When a heartbeat arrives, it forces its crossing count to zero and rebuilds its full 32-bit orbit count from the received byte. It flags a mismatch whenever the byte disagrees with what it expected. Every port on the trigger network, whether triggered or continuous, sees every heartbeat, because the marker is emitted unconditionally at each boundary.

Top module: `hb_frame_sync`

## Requirements
- R1: While reset is held and in the first cycle after it, gen_bc, gen_orbit, rx_bc and rx_orbit read 0, and hb_valid, hb_orbit, rx_resync and rx_mismatch read 0.
- R2: gen_bc counts 0, 1, … up to cfg_orbit_len−1, then returns to 0. gen_orbit increments by one on each return. cfg_orbit_len must be at least 2.
- R3: hb_valid is high for exactly one cycle, and only in a cycle where gen_bc is 0 and gen_orbit is a frame boundary. After reset, the first heartbeat appears when gen_orbit first equals the frame length, so none is sent before a whole frame has elapsed.
- R4: While hb_valid is high, hb_orbit equals bits 7:0 of gen_orbit. At all other times hb_orbit is 0.
- R5: The frame length is taken from cfg_frame_orbits at reset and at each boundary. A change made inside a frame does not alter that frame's length; it sets the length of the next frame. A value of 0 is treated as 1.
- R6: In the cycle after link_hb_valid is high at a clock edge, rx_bc is 0 and rx_resync is high. rx_resync is high for that one cycle only.
- R7: On a received heartbeat, let P be the orbit count the receiver would have reached without the heartbeat, and let D be link_hb_orbit − P[7:0], taken as a signed 8-bit value. rx_orbit becomes P + D.
- R8: rx_mismatch is high in the same cycle as rx_resync exactly when D is not zero. At all other times it is low.
- R9: Between heartbeats, rx_bc and rx_orbit advance by the same rule as R2.
- R10: When link_hb_valid and link_hb_orbit are tied to hb_valid and hb_orbit, rx_mismatch never rises. From the first heartbeat on, rx_bc and rx_orbit equal the previous cycle's gen_bc and gen_orbit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_orbit_len | input | 12 | Bunch crossings per orbit (at least 2) |
| cfg_frame_orbits | input | 16 | Orbits per time frame (0 treated as 1) |
| gen_bc | output | 12 | Generator bunch-crossing count |
| gen_orbit | output | 32 | Generator orbit count |
| hb_valid | output | 1 | Heartbeat marker, one cycle at each frame boundary |
| hb_orbit | output | 8 | Low orbit byte carried by the heartbeat |
| link_hb_valid | input | 1 | Heartbeat marker as received from the link |
| link_hb_orbit | input | 8 | Orbit byte as received from the link |
| rx_bc | output | 12 | Receiver bunch-crossing count |
| rx_orbit | output | 32 | Receiver reconstructed orbit count |
| rx_resync | output | 1 | One-cycle pulse after a heartbeat is taken |
| rx_mismatch | output | 1 | Received byte disagreed with the receiver's prediction |

## Verification
The hardest situation to reach is a received byte that differs from the receiver's prediction, above all where the difference crosses a 256-orbit carry. A looped-back link never produces one. The bench therefore overrides the link inputs with chosen bytes. Some are injected after running a short orbit for more than 256 orbits, so the prediction sits just past a carry, and a byte a few orbits behind has to borrow from the upper bits. A small sweep over orbit lengths and frame lengths, together with a frame-length change in mid-frame, covers the boundary timing.

// File: rtl/hb_pkg.sv
// Shared widths for the heartbeat generator and receiver.
// Assumes one clock domain; all widths are overridable per instance.
package hb_pkg;
    localparam int BC_W_DEF  = 12;  // bunch-crossing counter width
    localparam int ORB_W_DEF = 32;  // full orbit counter width
    localparam int HB_W_DEF  = 8;   // orbit bits carried by a heartbeat
    localparam int FRM_W_DEF = 16;  // frame-length register width
endpackage

// File: rtl/hb_bc_orbit_cnt.sv
// Bunch-crossing / orbit counter pair with an optional realign load.
// Crossing count wraps after cfg_len-1 (lengths below 2 wrap every cycle).
// A load forces the crossing count to 0 and the orbit count to ld_orbit.
// orbit_nxt is the orbit value the next edge produces when no load occurs.
module hb_bc_orbit_cnt #(
    parameter int BC_W  = hb_pkg::BC_W_DEF,
    parameter int ORB_W = hb_pkg::ORB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BC_W-1:0]  cfg_len,
    input  logic             ld_en,
    input  logic [ORB_W-1:0] ld_orbit,
    output logic [BC_W-1:0]  bc,
    output logic [ORB_W-1:0] orbit,
    output logic             orbit_end,
    output logic [ORB_W-1:0] orbit_nxt
);
    logic [BC_W:0] bc_inc;

    // Detect the last crossing of the orbit and the resulting orbit value.
    always_comb begin
        bc_inc    = {1'b0, bc} + 1'b1;
        orbit_end = (bc_inc >= {1'b0, cfg_len});
        orbit_nxt = orbit_end ? orbit + 1'b1 : orbit;
    end

    // Advance, wrap, or realign the counter pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc    <= '0;
            orbit <= '0;
        end else if (ld_en) begin
            bc    <= '0;
            orbit <= ld_orbit;
        end else begin
            bc    <= orbit_end ? '0 : bc_inc[BC_W-1:0];
            orbit <= orbit_nxt;
        end
    end

    AST_BC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && orbit_end) |=> (bc == '0 && orbit == $past(orbit) + 1'b1)); // R2
    AST_LOAD_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (bc == '0 && orbit == $past(ld_orbit))); // R6
endmodule

// File: rtl/hb_frame_timer.sv
// Counts orbits within a time frame and emits the heartbeat marker.
// The frame length is latched at reset and at each boundary, so a
// register change applies from the next frame. Zero is treated as one.
// Assumes orbit_end/orbit_nxt come from the generator counter.
module hb_frame_timer #(
    parameter int ORB_W = hb_pkg::ORB_W_DEF,
    parameter int HB_W  = hb_pkg::HB_W_DEF,
    parameter int FRM_W = hb_pkg::FRM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FRM_W-1:0] cfg_frame,
    input  logic             orbit_end,
    input  logic [ORB_W-1:0] orbit_nxt,
    output logic             hb_valid,
    output logic [HB_W-1:0]  hb_orbit
);
    logic [FRM_W-1:0] frame_cnt;
    logic [FRM_W-1:0] frame_len_q;
    logic [FRM_W-1:0] eff_len;
    logic             frame_last;

    // Clamp the requested length and detect the last orbit of the frame.
    always_comb begin
        eff_len    = (cfg_frame == '0) ? FRM_W'(1) : cfg_frame;
        frame_last = (({1'b0, frame_cnt} + 1'b1) >= {1'b0, frame_len_q});
    end

    // Track orbits in the frame and raise the marker at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt   <= '0;
            frame_len_q <= eff_len;
            hb_valid    <= 1'b0;
            hb_orbit    <= '0;
        end else begin
            hb_valid <= 1'b0;
            hb_orbit <= '0;
            if (orbit_end) begin
                if (frame_last) begin
                    frame_cnt   <= '0;
                    frame_len_q <= eff_len;
                    hb_valid    <= 1'b1;
                    hb_orbit    <= orbit_nxt[HB_W-1:0];
                end else begin
                    frame_cnt <= frame_cnt + 1'b1;
                end
            end
        end
    end

    AST_FRAME_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt < frame_len_q); // R5
endmodule

// File: rtl/hb_fe_receiver.sv
// Front-end side: free-running counters realigned by each heartbeat.
// The received orbit byte is extended against the orbit the receiver
// predicted for the same edge (nearest value within +/-128 orbits).
// Assumes the heartbeat marks crossing zero of its orbit.
module hb_fe_receiver #(
    parameter int BC_W  = hb_pkg::BC_W_DEF,
    parameter int ORB_W = hb_pkg::ORB_W_DEF,
    parameter int HB_W  = hb_pkg::HB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BC_W-1:0]  cfg_len,
    input  logic             link_valid,
    input  logic [HB_W-1:0]  link_orbit,
    output logic [BC_W-1:0]  rx_bc,
    output logic [ORB_W-1:0] rx_orbit,
    output logic             rx_resync,
    output logic             rx_mismatch
);
    localparam int EXT_W = ORB_W - HB_W;

    logic             rx_wrap;
    logic [ORB_W-1:0] pred;
    logic [HB_W-1:0]  diff;
    logic [ORB_W-1:0] ext_orbit;

    hb_bc_orbit_cnt #(.BC_W(BC_W), .ORB_W(ORB_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_len   (cfg_len),
        .ld_en     (link_valid),
        .ld_orbit  (ext_orbit),
        .bc        (rx_bc),
        .orbit     (rx_orbit),
        .orbit_end (rx_wrap),
        .orbit_nxt (pred)
    );

    // Extend the received byte to the full orbit nearest the prediction.
    always_comb begin
        diff      = link_orbit - pred[HB_W-1:0];
        ext_orbit = pred + {{EXT_W{diff[HB_W-1]}}, diff};
    end

    // Register the resync pulse and the mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_resync   <= 1'b0;
            rx_mismatch <= 1'b0;
        end else begin
            rx_resync   <= link_valid;
            rx_mismatch <= link_valid && (diff != '0);
        end
    end

    AST_RESYNC_BC0: assert property (@(posedge clk) disable iff (!rst_n)
        rx_resync |-> (rx_bc == '0)); // R6
    AST_MISMATCH_ON_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mismatch |-> rx_resync); // R8
    AST_RX_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_valid && rx_wrap) |=> (rx_bc == '0 && !rx_resync)); // R9
endmodule

// File: rtl/hb_frame_sync.sv
// Top: heartbeat generator (counters + frame timer) and front-end receiver.
// The receiver's link inputs are separate pins; tie them to hb_valid and
// hb_orbit for a direct link. Assumes cfg_orbit_len >= 2.
module hb_frame_sync #(
    parameter int BC_W  = hb_pkg::BC_W_DEF,
    parameter int ORB_W = hb_pkg::ORB_W_DEF,
    parameter int HB_W  = hb_pkg::HB_W_DEF,
    parameter int FRM_W = hb_pkg::FRM_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BC_W-1:0]  cfg_orbit_len,
    input  logic [FRM_W-1:0] cfg_frame_orbits,
    output logic [BC_W-1:0]  gen_bc,
    output logic [ORB_W-1:0] gen_orbit,
    output logic             hb_valid,
    output logic [HB_W-1:0]  hb_orbit,
    input  logic             link_hb_valid,
    input  logic [HB_W-1:0]  link_hb_orbit,
    output logic [BC_W-1:0]  rx_bc,
    output logic [ORB_W-1:0] rx_orbit,
    output logic             rx_resync,
    output logic             rx_mismatch
);
    logic             gen_end;
    logic [ORB_W-1:0] gen_nxt;

    hb_bc_orbit_cnt #(.BC_W(BC_W), .ORB_W(ORB_W)) u_gen_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_len   (cfg_orbit_len),
        .ld_en     (1'b0),
        .ld_orbit  ({ORB_W{1'b0}}),
        .bc        (gen_bc),
        .orbit     (gen_orbit),
        .orbit_end (gen_end),
        .orbit_nxt (gen_nxt)
    );

    hb_frame_timer #(.ORB_W(ORB_W), .HB_W(HB_W), .FRM_W(FRM_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_frame (cfg_frame_orbits),
        .orbit_end (gen_end),
        .orbit_nxt (gen_nxt),
        .hb_valid  (hb_valid),
        .hb_orbit  (hb_orbit)
    );

    hb_fe_receiver #(.BC_W(BC_W), .ORB_W(ORB_W), .HB_W(HB_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_len     (cfg_orbit_len),
        .link_valid  (link_hb_valid),
        .link_orbit  (link_hb_orbit),
        .rx_bc       (rx_bc),
        .rx_orbit    (rx_orbit),
        .rx_resync   (rx_resync),
        .rx_mismatch (rx_mismatch)
    );

    AST_HB_AT_BC0: assert property (@(posedge clk) disable iff (!rst_n)
        hb_valid |-> (gen_bc == '0)); // R3
    AST_HB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && cfg_orbit_len >= BC_W'(2)) |=> !hb_valid); // R3
    AST_HB_ORBIT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        hb_valid |-> (hb_orbit == gen_orbit[HB_W-1:0])); // R4
    AST_HB_QUIET_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !hb_valid |-> (hb_orbit == '0)); // R4
endmodule

// File: tb/hb_frame_sync_test.sv
`timescale 1ns/1ps
module hb_frame_sync_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_orbit_len = 12'd5;
    logic [15:0] cfg_frame_orbits = 16'd3;
    logic [11:0] gen_bc, rx_bc;
    logic [31:0] gen_orbit, rx_orbit;
    logic        hb_valid, rx_resync, rx_mismatch;
    logic [7:0]  hb_orbit;
    logic        inj_en = 1'b0, inj_v = 1'b0;
    logic [7:0]  inj_o = 8'd0;
    logic        link_v;
    logic [7:0]  link_o;

    assign link_v = inj_en ? inj_v : hb_valid;
    assign link_o = inj_en ? inj_o : hb_orbit;

    hb_frame_sync uut (
        .clk(clk), .rst_n(rst_n), .cfg_orbit_len(cfg_orbit_len),
        .cfg_frame_orbits(cfg_frame_orbits), .gen_bc(gen_bc), .gen_orbit(gen_orbit),
        .hb_valid(hb_valid), .hb_orbit(hb_orbit), .link_hb_valid(link_v),
        .link_hb_orbit(link_o), .rx_bc(rx_bc), .rx_orbit(rx_orbit),
        .rx_resync(rx_resync), .rx_mismatch(rx_mismatch)
    );

    always #10 clk = ~clk;  // 50 MHz

    int unsigned n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    // bench model state
    longint      t, nb, L, mbc, morb, pbc, porb;
    bit          er, em, seen_hb, clean;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
        end
    endtask

    function automatic longint dflt_frame(input longint f);
        return (f == 0) ? 1 : f;
    endfunction

    // Compare all outputs against the arithmetic model for cycle t.
    task automatic check_now();
        longint ebc, eorb, eo;
        bit     ehb;
        ebc  = t % L;
        eorb = t / L;
        ehb  = (t == nb * L);
        eo   = ehb ? (nb % 256) : 0;
        chk(gen_bc == ebc[11:0], "R2 gen_bc", gen_bc, ebc);
        chk(gen_orbit == eorb[31:0], "R2 gen_orbit", gen_orbit, eorb);
        chk(hb_valid == ehb, "R3 hb_valid", hb_valid, ehb);
        chk(hb_orbit == eo[7:0], "R4 hb_orbit", hb_orbit, eo);
        if (ehb) begin
            nb = nb + dflt_frame(cfg_frame_orbits);  // R5 latched at boundary
            seen_hb = 1'b1;
        end
        chk(rx_resync == er, "R6 rx_resync", rx_resync, er);
        chk(rx_bc == mbc[11:0], er ? "R6 rx_bc" : "R9 rx_bc", rx_bc, mbc);
        chk(rx_orbit == morb[31:0], er ? "R7 rx_orbit" : "R9 rx_orbit", rx_orbit, morb);
        chk(rx_mismatch == em, "R8 rx_mismatch", rx_mismatch, em);
        if (clean && seen_hb && !ehb) begin
            chk(rx_bc == pbc[11:0], "R10 rx_bc lag", rx_bc, pbc);
            chk(rx_orbit == porb[31:0], "R10 rx_orbit lag", rx_orbit, porb);
            chk(!rx_mismatch, "R10 no mismatch", rx_mismatch, 0);
        end
        pbc  = ebc;
        porb = eorb;
    endtask

    // One clock: capture link values at the coming edge, then check.
    task automatic step();
        bit         lv;
        logic [7:0] lo;
        longint     pred, d;
        lv = inj_en ? inj_v : hb_valid;
        lo = inj_en ? inj_o : hb_orbit;
        @(negedge clk);
        t++;
        if (lv) begin
            pred = (mbc == L - 1) ? morb + 1 : morb;
            d    = longint'(lo) - (pred % 256);
            if (d > 127) d = d - 256;
            if (d < -128) d = d + 256;
            morb = pred + d;
            mbc  = 0;
            er   = 1'b1;
            em   = (d != 0);
        end else begin
            er = 1'b0;
            em = 1'b0;
            if (mbc == L - 1) begin
                mbc  = 0;
                morb = morb + 1;
            end else begin
                mbc = mbc + 1;
            end
        end
        check_now();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset(input int l, input int f);
        cfg_orbit_len    = l[11:0];
        cfg_frame_orbits = f[15:0];
        inj_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs held at reset values
        chk(gen_bc == 0 && gen_orbit == 0 && !hb_valid && hb_orbit == 0,
            "R1 gen in reset", gen_orbit, 0);
        chk(rx_bc == 0 && rx_orbit == 0 && !rx_resync && !rx_mismatch,
            "R1 rx in reset", rx_orbit, 0);
        rst_n = 1'b1;
        L = l; nb = dflt_frame(f); t = 0; mbc = 0; morb = 0;
        er = 0; em = 0; seen_hb = 0; clean = 1; pbc = 0; porb = 0;
        check_now();  // R1 first cycle after reset
    endtask

    // Drive one injected heartbeat byte over the link for a single edge.
    task automatic inject(input logic [7:0] b);
        clean  = 1'b0;
        inj_en = 1'b1; inj_v = 1'b1; inj_o = b;
        step();
        inj_en = 1'b0; inj_v = 1'b0;
    endtask

    function automatic logic [7:0] pred_byte();
        longint p;
        p = (mbc == L - 1) ? morb + 1 : morb;
        return p[7:0];
    endfunction

    initial begin
        do_reset(5, 3);
        run(200);
        // R5: change frame length in mid-frame (boundaries at orbit 3, then
        // 6 keeps length 3, afterwards length 2)
        do_reset(5, 3);
        run(20);
        cfg_frame_orbits = 16'd2;
        run(120);
        cfg_frame_orbits = 16'd0;  // R5: zero acts as one
        run(40);
        // R2/R3 sweep over small configurations
        for (int l = 2; l <= 6; l++)
            for (int f = 1; f <= 3; f++) begin
                do_reset(l, f);
                run(l * f * 4 + 7);
            end
        // R7/R10: direct link across a 256-orbit carry
        do_reset(2, 1);
        run(600);
        // R7/R8: injected bytes on a long frame
        do_reset(4, 50);
        run(9);
        inject(8'd5);
        run(6);
        inject(pred_byte());          // R8 matching byte, no mismatch
        run(3);
        inject(pred_byte() - 8'd7);   // R7 behind prediction
        run(5);
        // R7: borrow and carry around the byte boundary
        do_reset(2, 200);
        run(520);
        inject(8'd250);
        run(4);
        inject(pred_byte() + 8'd100);
        run(4);
        inject(pred_byte() - 8'd128);
        run(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule